// File: doc/BRIEF.md
# Host-to-16-bit terminal access bridge

This block sits between a 32-bit host target port and the 16-bit, word-addressed local bus of one protocol terminal. The host addresses the terminal with byte offsets; the bridge selects either the terminal's register window or its 64K-word shared RAM window through a space input. It turns each host access into one or two local cycles. Register accesses are always single 16-bit cycles. A 32-bit memory access becomes two back-to-back cycles to adjacent word addresses. Host writes are posted into a FIFO so that the host can run ahead of the slower local bus. Reads wait until every posted write has reached the terminal.

The host port uses a request/ready handshake. A write is taken in any cycle in which the FIFO has room. A read is taken only when the FIFO is empty and the sequencer is idle, and its data comes back later with a one-cycle valid pulse. The local bus holds a request until the terminal acknowledges it. A separate path merges the interrupt lines of up to four terminals into one active-low host interrupt.

Top module: `term_access_bridge`

## Requirements
- R1: In the register space (mem_i=0), the register index is dw_addr_i[7:2], so byte offset 0x004·n addresses register n. Every register access is exactly one local cycle with lb_mem_o=0 and lb_addr_o equal to the index. A register write carries wdata_i[15:0], and byte enables are ignored.
- R2: A register read returns the local data in rdata_o[15:0] and zero in rdata_o[31:16].
- R3: Register indices 32 to 63 (index bit 5 set) form the test range. While test_en_i=0, a write there is accepted and discarded without a local cycle, and a read returns zero without a local cycle. While test_en_i=1, they behave as in R1 and R2.
- R4: In the memory space (mem_i=1), the local word address is the host byte offset divided by two: {dw_addr_i[16:2], h}, where h=0 selects bits 15:0 and h=1 selects bits 31:16 of the host data. lb_mem_o is 1.
- R5: A memory access with enables in both halves (be_i[1:0]≠0 and be_i[3:2]≠0) makes two local cycles. The even word comes first, carrying or returning bits 15:0, and the odd word follows, carrying or returning bits 31:16.
- R6: A memory access with enables in one half only makes a single local cycle to that half, and a read returns zero in the other half. With be_i=0, no local cycle is made and a read returns zero.
- R7: The FIFO holds FIFO_DEPTH entries, and one more write can wait inside the sequencer. While the FIFO is full, rdy_o is low for writes. No accepted write is lost, and local cycles follow acceptance order.
- R8: A read is not accepted (rdy_o low) while posted writes are pending or a local cycle is in progress, so a read always observes every earlier write.
- R9: lb_req_o, lb_addr_o, lb_we_o, lb_mem_o and lb_wdata_o stay stable until the cycle in which lb_ack_i is high.
- R10: rvalid_o is high for the one cycle after the edge that samples the final acknowledge. For a read with no local cycle, it is high for the cycle after the accepting edge.
- R11: irq_no is low exactly when any bit of irq_i is high, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request valid |
| we_i | input | 1 | Host write (1) or read (0) |
| mem_i | input | 1 | Space select: 1 memory, 0 registers |
| dw_addr_i | input | 15 | Host byte offset bits 16:2 |
| be_i | input | 4 | Host byte enables |
| wdata_i | input | 32 | Host write data |
| test_en_i | input | 1 | Opens the register test range |
| rdy_o | output | 1 | Host request accepted this cycle |
| rvalid_o | output | 1 | Read data valid pulse |
| rdata_o | output | 32 | Read data |
| lb_req_o | output | 1 | Local cycle request |
| lb_we_o | output | 1 | Local write |
| lb_mem_o | output | 1 | Local space: 1 memory, 0 registers |
| lb_addr_o | output | 16 | Local word address or register index |
| lb_wdata_o | output | 16 | Local write data |
| lb_ack_i | input | 1 | Local cycle acknowledge |
| lb_rdata_i | input | 16 | Local read data, valid with lb_ack_i |
| irq_i | input | N_TERM | Terminal interrupt requests, active high |
| irq_no | output | 1 | Merged host interrupt, active low |

## Verification
Each result has its own timing, and the bench samples it on a falling edge 1 ns late.

- **Host handshake:** rdy_o is judged before the rising edge that would take the request.
- **Read data:** rvalid_o must be seen exactly 5 ns after the terminal model raised its final acknowledge, which is one clock later. For a read with no local cycle, it must be seen 3 ns after the accepting rising edge.
- **Local cycles:** These are logged by the terminal model and compared in order with an expected list. The list is built when each host access is issued, so results are checked regardless of latency, back-pressure and FIFO depth.
- **Interrupt:** irq_no is combinational and is checked 1 ns after irq_i changes.

// File: rtl/term_bridge_pkg.sv
package term_bridge_pkg;
  localparam int HDATA_W   = 32;
  localparam int LDATA_W   = 16;
  localparam int LADDR_W   = 16;
  localparam int REG_IDX_W = 6;
  localparam int DW_W      = LADDR_W - 1;
  localparam int BE_W      = HDATA_W / 8;

  typedef struct packed {
    logic               we;
    logic               mem;
    logic [DW_W-1:0]    base;   // dword address (mem) or register index
    logic               lo;     // cycle on word 0 needed
    logic               hi;     // cycle on word 1 needed
    logic [HDATA_W-1:0] wdata;
  } op_t;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import term_bridge_pkg::*;
(
  input  logic               we_i,
  input  logic               mem_i,
  input  logic [DW_W-1:0]    dw_addr_i,
  input  logic [BE_W-1:0]    be_i,
  input  logic [HDATA_W-1:0] wdata_i,
  input  logic               test_en_i,
  output op_t                op_o,
  output logic               live_o
);
  logic [REG_IDX_W-1:0] idx;
  logic                 in_test;

  assign idx     = dw_addr_i[REG_IDX_W-1:0];
  assign in_test = idx[REG_IDX_W-1];

  always_comb begin
    op_o       = '0;
    op_o.we    = we_i;
    op_o.mem   = mem_i;
    op_o.wdata = wdata_i;
    if (mem_i) begin
      op_o.base = dw_addr_i;
      op_o.lo   = |be_i[BE_W/2-1:0];
      op_o.hi   = |be_i[BE_W-1:BE_W/2];
    end else begin
      op_o.base = DW_W'(idx);
      op_o.lo   = !in_test || test_en_i;
      op_o.hi   = 1'b0;
    end
  end

  assign live_o = op_o.lo | op_o.hi;
endmodule

// File: rtl/wr_fifo.sv
module wr_fifo #(
  parameter int DEPTH = 72,
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= ptr_inc(wr_q);
      if (pop_i)  rd_q <= ptr_inc(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= din_i;
  end

  assign dout_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/lb_seq.sv
module lb_seq
  import term_bridge_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fifo_empty_i,
  input  op_t                fifo_op_i,
  output logic               fifo_pop_o,
  input  logic               rd_req_i,
  input  op_t                rd_op_i,
  input  logic               rd_live_i,
  output logic               rd_take_o,
  output logic               lb_req_o,
  output logic               lb_we_o,
  output logic               lb_mem_o,
  output logic [LADDR_W-1:0] lb_addr_o,
  output logic [LDATA_W-1:0] lb_wdata_o,
  input  logic               lb_ack_i,
  input  logic [LDATA_W-1:0] lb_rdata_i,
  output logic               rvalid_o,
  output logic [HDATA_W-1:0] rdata_o
);
  typedef enum logic {S_IDLE, S_RUN} state_e;

  state_e             state_q;
  op_t                op_q;
  logic               half_q;
  logic [HDATA_W-1:0] rbuf_q, rd_merge, rdata_q;
  logic               rvalid_q;
  logic               idle;

  assign idle       = (state_q == S_IDLE);
  assign fifo_pop_o = idle && !fifo_empty_i;
  assign rd_take_o  = idle && fifo_empty_i && rd_req_i;

  assign lb_req_o   = (state_q == S_RUN);
  assign lb_we_o    = op_q.we;
  assign lb_mem_o   = op_q.mem;
  assign lb_addr_o  = op_q.mem ? {op_q.base, half_q}
                               : LADDR_W'(op_q.base[REG_IDX_W-1:0]);
  assign lb_wdata_o = half_q ? op_q.wdata[HDATA_W-1:LDATA_W]
                             : op_q.wdata[LDATA_W-1:0];

  always_comb begin
    rd_merge = rbuf_q;
    if (half_q) rd_merge[HDATA_W-1:LDATA_W] = lb_rdata_i;
    else        rd_merge[LDATA_W-1:0]       = lb_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      op_q     <= '0;
      half_q   <= 1'b0;
      rbuf_q   <= '0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (fifo_pop_o) begin
            op_q    <= fifo_op_i;
            half_q  <= !fifo_op_i.lo;
            state_q <= S_RUN;
          end else if (rd_take_o) begin
            rbuf_q <= '0;
            if (rd_live_i) begin
              op_q    <= rd_op_i;
              half_q  <= !rd_op_i.lo;
              state_q <= S_RUN;
            end else begin
              rvalid_q <= 1'b1;
              rdata_q  <= '0;
            end
          end
        end
        default: begin
          if (lb_ack_i) begin
            rbuf_q <= rd_merge;
            if (!half_q && op_q.hi) begin
              half_q <= 1'b1;
            end else begin
              state_q <= S_IDLE;
              if (!op_q.we) begin
                rvalid_q <= 1'b1;
                rdata_q  <= rd_merge;
              end
            end
          end
        end
      endcase
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int N_SRC = 4
) (
  input  logic [N_SRC-1:0] irq_i,
  output logic             irq_no
);
  logic [N_SRC:0] any;

  assign any[0] = 1'b0;
  for (genvar g = 0; g < N_SRC; g++) begin : g_or
    assign any[g+1] = any[g] | irq_i[g];
  end

  assign irq_no = !any[N_SRC];
endmodule

// File: rtl/term_access_bridge.sv
module term_access_bridge
  import term_bridge_pkg::*;
#(
  parameter int FIFO_DEPTH = 72,
  parameter int N_TERM     = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic               mem_i,
  input  logic [DW_W-1:0]    dw_addr_i,
  input  logic [BE_W-1:0]    be_i,
  input  logic [HDATA_W-1:0] wdata_i,
  input  logic               test_en_i,
  output logic               rdy_o,
  output logic               rvalid_o,
  output logic [HDATA_W-1:0] rdata_o,
  output logic               lb_req_o,
  output logic               lb_we_o,
  output logic               lb_mem_o,
  output logic [LADDR_W-1:0] lb_addr_o,
  output logic [LDATA_W-1:0] lb_wdata_o,
  input  logic               lb_ack_i,
  input  logic [LDATA_W-1:0] lb_rdata_i,
  input  logic [N_TERM-1:0]  irq_i,
  output logic               irq_no
);
  localparam int OP_W = $bits(op_t);

  op_t  host_op, fifo_op;
  logic host_live;
  logic fifo_full, fifo_empty, fifo_pop, fifo_push;
  logic rd_req, rd_take;

  cmd_decode i_dec (
    .we_i      (we_i),
    .mem_i     (mem_i),
    .dw_addr_i (dw_addr_i),
    .be_i      (be_i),
    .wdata_i   (wdata_i),
    .test_en_i (test_en_i),
    .op_o      (host_op),
    .live_o    (host_live)
  );

  // dead writes (test range, no enables) are accepted but never queued
  assign fifo_push = req_i && we_i && !fifo_full && host_live;
  assign rd_req    = req_i && !we_i;
  assign rdy_o     = we_i ? !fifo_full : rd_take;

  wr_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(OP_W)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (fifo_push),
    .din_i   (host_op),
    .pop_i   (fifo_pop),
    .dout_o  (fifo_op),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  lb_seq i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fifo_empty_i (fifo_empty),
    .fifo_op_i    (fifo_op),
    .fifo_pop_o   (fifo_pop),
    .rd_req_i     (rd_req),
    .rd_op_i      (host_op),
    .rd_live_i    (host_live),
    .rd_take_o    (rd_take),
    .lb_req_o     (lb_req_o),
    .lb_we_o      (lb_we_o),
    .lb_mem_o     (lb_mem_o),
    .lb_addr_o    (lb_addr_o),
    .lb_wdata_o   (lb_wdata_o),
    .lb_ack_i     (lb_ack_i),
    .lb_rdata_i   (lb_rdata_i),
    .rvalid_o     (rvalid_o),
    .rdata_o      (rdata_o)
  );

  irq_merge #(.N_SRC(N_TERM)) i_irq (
    .irq_i  (irq_i),
    .irq_no (irq_no)
  );
endmodule

// File: rtl/term_access_bridge_chk.sv
module term_access_bridge_chk
  import term_bridge_pkg::*;
#(
  parameter int N_TERM = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic               rdy_o,
  input logic               rvalid_o,
  input logic               lb_req_o,
  input logic               lb_we_o,
  input logic               lb_mem_o,
  input logic [LADDR_W-1:0] lb_addr_o,
  input logic [LDATA_W-1:0] lb_wdata_o,
  input logic               lb_ack_i,
  input logic [N_TERM-1:0]  irq_i,
  input logic               irq_no
);
  a_r9_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lb_req_o && !lb_ack_i |=> lb_req_o && $stable(lb_addr_o) && $stable(lb_we_o)
                              && $stable(lb_mem_o) && $stable(lb_wdata_o));

  a_r8_read_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && rdy_o |-> !lb_req_o);

  a_r10_rvalid_after_cycles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> !lb_req_o);

  a_r1_reg_index_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lb_req_o && !lb_mem_o |-> lb_addr_o[LADDR_W-1:REG_IDX_W] == '0);

  a_r11_irq_any: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_i) |-> !irq_no);

  a_r11_irq_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|irq_i) |-> irq_no);
endmodule

bind term_access_bridge term_access_bridge_chk #(.N_TERM(N_TERM)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .rdy_o      (rdy_o),
  .rvalid_o   (rvalid_o),
  .lb_req_o   (lb_req_o),
  .lb_we_o    (lb_we_o),
  .lb_mem_o   (lb_mem_o),
  .lb_addr_o  (lb_addr_o),
  .lb_wdata_o (lb_wdata_o),
  .lb_ack_i   (lb_ack_i),
  .irq_i      (irq_i),
  .irq_no     (irq_no)
);

// File: tb/test_term_access_bridge.sv
`timescale 1ns/1ps
module test_term_access_bridge;
  localparam int DEPTH = 72;
  localparam int NT    = 4;

  typedef struct packed {
    logic        we;
    logic        mem;
    logic [15:0] a;
    logic [15:0] d;
  } tr_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 0, we = 0, mem = 0, test_en = 0;
  logic [16:2] addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic        rdy, rvalid;
  logic [31:0] rdata;
  logic        lb_req, lb_we, lb_mem, lb_ack = 0;
  logic [15:0] lb_addr, lb_wdata, lb_rdata = '0;
  logic [NT-1:0] irq = '0;
  logic        irq_n;

  int    n_tests = 0, n_fail = 0;
  bit    hold = 0, ended = 0;
  realtime t_ack = 0;
  int    last_wait;

  tr_t   log_q[$], exp_q[$];
  logic [15:0] lmem [int];
  logic [15:0] lreg [64];
  logic [15:0] smem [int];
  logic [15:0] sreg [64];

  always #2 clk = ~clk;

  term_access_bridge #(.FIFO_DEPTH(DEPTH), .N_TERM(NT)) i_term_access_bridge (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .mem_i(mem),
    .dw_addr_i(addr), .be_i(be), .wdata_i(wdata), .test_en_i(test_en),
    .rdy_o(rdy), .rvalid_o(rvalid), .rdata_o(rdata),
    .lb_req_o(lb_req), .lb_we_o(lb_we), .lb_mem_o(lb_mem), .lb_addr_o(lb_addr),
    .lb_wdata_o(lb_wdata), .lb_ack_i(lb_ack), .lb_rdata_i(lb_rdata),
    .irq_i(irq), .irq_no(irq_n)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic finish_tb();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // terminal model
  initial begin
    int wc;
    wc = 0;
    for (int i = 0; i < 64; i++) lreg[i] = '0;
    forever begin
      @(negedge clk);
      if (lb_ack) lb_ack = 0;
      else if (lb_req && !hold) begin
        if (wc == 0) begin
          tr_t t;
          t.we = lb_we; t.mem = lb_mem; t.a = lb_addr;
          if (lb_we) begin
            t.d = lb_wdata;
            if (lb_mem) lmem[int'(lb_addr)] = lb_wdata;
            else lreg[lb_addr[5:0]] = lb_wdata;
          end else begin
            if (lb_mem) t.d = lmem.exists(int'(lb_addr)) ? lmem[int'(lb_addr)] : 16'h0;
            else t.d = lreg[lb_addr[5:0]];
            lb_rdata = t.d;
          end
          log_q.push_back(t);
          lb_ack = 1;
          t_ack = $realtime;
          wc = $urandom % 3;
        end else wc--;
      end
    end
  end

  // expected local cycles and read data per R1..R6
  function automatic logic [31:0] model(input logic w, input logic m, input logic [16:2] a,
                                        input logic [3:0] b, input logic [31:0] d, output bit any);
    logic [31:0] r;
    tr_t t;
    r = '0; any = 0;
    if (!m) begin
      logic [5:0] idx;
      idx = a[7:2];
      if (!idx[5] || test_en) begin
        any = 1;
        if (w) sreg[idx] = d[15:0];
        t = '{w, 1'b0, 16'(idx), sreg[idx]};
        exp_q.push_back(t);
        r = {16'h0, sreg[idx]};
      end
    end else begin
      for (int h = 0; h < 2; h++) begin
        if (|b[h*2 +: 2]) begin
          int wa;
          wa = int'({a, h[0]});
          any = 1;
          if (w) smem[wa] = d[h*16 +: 16];
          if (!smem.exists(wa)) smem[wa] = 16'h0;
          t = '{w, 1'b1, 16'(wa), smem[wa]};
          exp_q.push_back(t);
          r[h*16 +: 16] = smem[wa];
        end
      end
    end
    return r;
  endfunction

  task automatic issue(input logic w, input logic m, input logic [16:2] a, input logic [3:0] b,
                       input logic [31:0] d, input string rq);
    logic [31:0] rexp;
    bit any;
    realtime tp;
    rexp = model(w, m, a, b, d, any);
    @(negedge clk);
    req = 1; we = w; mem = m; addr = a; be = b; wdata = d;
    last_wait = 0;
    #1;
    while (!rdy) begin @(negedge clk); #1; last_wait++; end
    @(posedge clk);
    tp = $realtime;
    #1 req = 0;
    if (!w) begin
      do begin @(negedge clk); #1; end while (!rvalid);
      chk(rdata === rexp, rq, 64'(rdata), 64'(rexp));
      if (any) chk(($realtime - t_ack) == 5.0, "R10 final-ack timing", 64'($realtime - t_ack), 64'd5);
      else     chk(($realtime - tp) == 3.0, "R10 no-cycle timing", 64'($realtime - tp), 64'd3);
      @(negedge clk); #1;
      chk(rvalid === 1'b0, "R10 single pulse", 64'(rvalid), 64'd0);
    end
  endtask

  task automatic drain();
    int quiet;
    quiet = 0;
    while (quiet < 12) begin @(negedge clk); #1; if (lb_req) quiet = 0; else quiet++; end
  endtask

  task automatic check_log(input string rq);
    drain();
    while (exp_q.size() > 0) begin
      tr_t e, g;
      e = exp_q.pop_front();
      if (log_q.size() == 0) begin
        chk(0, rq, 64'd0, 64'(e));
      end else begin
        g = log_q.pop_front();
        chk(g === e, rq, 64'(g), 64'(e));
      end
    end
    chk(log_q.size() == 0, {rq, " extra local cycles"}, 64'(log_q.size()), 64'd0);
    log_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 64'd1, 64'd0);
    finish_tb();
  end

  initial begin
    void'($urandom(32'h5eed_1553));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    chk(lb_req === 1'b0, "reset lb_req", 64'(lb_req), 64'd0);
    chk(rvalid === 1'b0, "reset rvalid", 64'(rvalid), 64'd0);
    chk(irq_n === 1'b1, "R11 reset irq", 64'(irq_n), 64'd1);

    // R1, R2: register write then read, upper bits ignored on write, zero on read
    issue(1, 0, 15'h0005, 4'hF, 32'hABCD_1234, "R1 reg write");
    issue(0, 0, 15'h0005, 4'hF, 32'h0, "R2 reg read");
    issue(1, 0, 15'h401F, 4'h1, 32'h5555_BEEF, "R1 reg index from bits 7:2");
    issue(0, 0, 15'h001F, 4'h0, 32'h0, "R2 reg read idx 31");
    check_log("R1 reg cycles");

    // R3: test range closed then open
    test_en = 0;
    issue(1, 0, 15'h0028, 4'hF, 32'h0000_7777, "R3 closed write");
    issue(0, 0, 15'h0028, 4'hF, 32'h0, "R3 closed read zero");
    test_en = 1;
    issue(1, 0, 15'h0028, 4'hF, 32'h0000_7777, "R3 open write");
    issue(0, 0, 15'h0028, 4'hF, 32'h0, "R3 open read");
    test_en = 0;
    issue(0, 0, 15'h003F, 4'hF, 32'h0, "R3 closed read after open");
    check_log("R3 test range cycles");

    // R4, R5: double word at byte offset 0x1238 -> words 0x91C, 0x91D
    issue(1, 1, 15'h048E, 4'hF, 32'h1111_2222, "R5 dword write");
    issue(0, 1, 15'h048E, 4'hF, 32'h0, "R5 dword read");
    check_log("R4 R5 word order");

    // R6: single halves and empty enables
    issue(1, 1, 15'h0100, 4'h3, 32'hDEAD_0A0A, "R6 low half write");
    issue(1, 1, 15'h0101, 4'h4, 32'h0B0B_DEAD, "R6 high half write");
    issue(0, 1, 15'h0101, 4'hC, 32'h0, "R6 high half read");
    issue(0, 1, 15'h0100, 4'hF, 32'h0, "R6 dword read after low write");
    issue(1, 1, 15'h0100, 4'h0, 32'hFFFF_FFFF, "R6 empty write");
    issue(0, 1, 15'h0100, 4'h0, 32'h0, "R6 empty read zero");
    check_log("R6 half cycles");

    // R8: read waits behind posted writes
    hold = 1;
    issue(1, 1, 15'h0200, 4'hF, 32'hCAFE_F00D, "R8 posted write");
    issue(1, 0, 15'h0002, 4'hF, 32'h0000_0042, "R8 posted reg write");
    fork
      issue(0, 1, 15'h0200, 4'hF, 32'h0, "R8 read sees prior write");
      begin
        for (int i = 0; i < 4; i++) begin
          @(negedge clk); #2;
          chk(rdy === 1'b0, "R8 read held off", 64'(rdy), 64'd0);
        end
        hold = 0;
      end
    join
    check_log("R8 ordering");

    // R7: fill FIFO plus sequencer stage, next write must stall
    hold = 1;
    begin
      int stalls;
      stalls = 0;
      for (int i = 0; i < DEPTH + 1; i++) begin
        issue(1, 1, 15'(16'h0300 + i), 4'hF, {16'(i), 16'(~i)}, "R7 fill");
        stalls += last_wait;
      end
      chk(stalls == 0, "R7 no stall below capacity", 64'(stalls), 64'd0);
    end
    fork
      issue(1, 1, 15'h0400, 4'hF, 32'h7777_8888, "R7 stalled write");
      begin
        for (int i = 0; i < 4; i++) begin
          @(negedge clk); #2;
          chk(rdy === 1'b0, "R7 full stall", 64'(rdy), 64'd0);
        end
        hold = 0;
      end
    join
    check_log("R7 order after stall");
    issue(0, 1, 15'h0400, 4'hF, 32'h0, "R7 stalled write kept");
    check_log("R7 readback cycles");

    // R11: every interrupt pattern
    for (int p = 0; p < (1 << NT); p++) begin
      @(negedge clk) irq = NT'(p);
      #1 chk(irq_n === (p == 0), "R11 irq merge", 64'(irq_n), 64'(p == 0));
    end
    irq = '0;

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic w, m;
      logic [16:2] a;
      w = 1'($urandom);
      m = 1'($urandom);
      test_en = ($urandom % 4) == 0;
      a = m ? 15'(16'h0500 + ($urandom % 16)) : 15'($urandom);
      issue(w, m, a, 4'($urandom), $urandom, w ? "R5 random write" : "R6 random read");
      if (n % 50 == 49) check_log("R4 random cycles");
    end
    check_log("R4 random cycles");

    finish_tb();
  end
endmodule